// File: doc/BRIEF.md
# Indexed pointer extension execution unit

This unit decodes and executes an optional group of eight instructions for an 8-bit microcontroller core. The group adds arithmetic on three 12-bit data-memory pointers, a literal push onto a software stack addressed by pointer 2, a call through the working register, and two memory-to-memory moves whose source is pointer 2 plus a 7-bit offset. The core presents one 16-bit instruction word per valid cycle. A two-word move is split across two valid words, and any number of idle cycles may separate them.

The unit updates its pointers in place and issues read and write requests to a synchronous data memory. Read data returns in the cycle after the read request. It raises call and return requests for the core's own stack logic. On the word that completes each instruction it reports how many cycles that instruction costs. A strap input enables the whole group. While the strap is low, every extension encoding executes as a no-operation. The core can load any pointer through a dedicated load port.

Top module: `ptr_ext_unit`

## Requirements
- R1: After reset all three pointers read 0, and no memory, call or return request is active while no word is presented.
- R2: With the enable strap high, a word 0xE8 or 0xE9 in bits 15:8 with ff = bits 7:6 in 0..2 adds (0xE8) or subtracts (0xE9) the 6-bit literal in bits 5:0 to or from pointer ff, effective on the next cycle. done_o is high with cyc_o = 1 and there is no return request.
- R3: The same opcodes with ff = 11 act on pointer 2 and raise ret_req_o, with done_o high and cyc_o = 2.
- R4: Word 0xEA kk writes literal kk to the address in pointer 2 (mem_we_o) in that same cycle and leaves pointer 2 decremented by one. cyc_o is 1.
- R5: Word 0x0014 raises call_req_o with done_o and cyc_o = 2, and leaves all pointers unchanged.
- R6: Word 0xEB with bit 7 clear reads memory at pointer 2 plus bits 6:0 (zero-extended) without done_o. The next valid word then writes the read byte to the absolute address in its bits 11:0, with done_o and cyc_o = 2.
- R7: Word 0xEB with bit 7 set reads as in R6. The next valid word then writes the byte to pointer 2 plus that word's bits 6:0.
- R8: With the enable strap low, every extension encoding produces done_o with cyc_o = 1, no memory, call or return request, and no pointer change.
- R9: A word with prefix 0xF in bits 15:12 presented outside a move, or any non-extension word, executes as a no-operation with cyc_o = 1.
- R10: All pointer and address arithmetic wraps modulo 4096.
- R11: When idle cycles separate the two words of a move, the byte written is still the one read at the first word.
- R12: A pointer load (ptr_ld_i, select 0..2) replaces the selected pointer on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_en_i | input | 1 | Extension enable strap |
| instr_valid_i | input | 1 | instr_i carries a word this cycle |
| instr_i | input | 16 | Instruction word |
| ptr_ld_i | input | 1 | Load a pointer |
| ptr_ld_sel_i | input | 2 | Pointer to load |
| ptr_ld_val_i | input | PTR_W | Load value |
| mem_rdata_i | input | DATA_W | Read data, valid the cycle after mem_re_o |
| mem_re_o | output | 1 | Memory read request |
| mem_we_o | output | 1 | Memory write request |
| mem_addr_o | output | PTR_W | Memory address |
| mem_wdata_o | output | DATA_W | Memory write data |
| done_o | output | 1 | This word completes an instruction |
| cyc_o | output | 2 | Cycle cost of the completed instruction |
| call_req_o | output | 1 | Call through working register |
| ret_req_o | output | 1 | Return from subroutine |
| ptr_o | output | 3*PTR_W | Pointers, pointer 0 in the low bits |

## Verification
A pointer that drifts shows up at ptr_o on the cycle after the faulty word. It also shows up in the address of the next push or move that uses pointer 2, because every stack access goes through that pointer. If the two-word sequencing state is wrong, the following word is decoded as the wrong instruction. That word then shows a missing or extra done_o, or an unexpected read or write request, in that same cycle. A lost read-data hold shows only on the write of a move that has idle cycles before its second word, so those gaps are generated on purpose.

// File: rtl/ptr_ext_pkg.sv
package ptr_ext_pkg;
  localparam int unsigned INSTR_W = 16;
  localparam int unsigned N_PTR   = 3;
  localparam int unsigned OFF_W   = 7;
  localparam int unsigned LIT6_W  = 6;
  localparam int unsigned LIT8_W  = 8;
  localparam int unsigned ABS_W   = 12;
  localparam int unsigned CYC_W   = 2;

  typedef enum logic [3:0] {
    OP_NOP,
    OP_ADD,
    OP_SUB,
    OP_ADD_RET,
    OP_SUB_RET,
    OP_PUSH,
    OP_CALLW,
    OP_MV_ABS1,
    OP_MV_IDX1,
    OP_MV2
  } op_e;
endpackage

// File: rtl/ptr_ext_decode.sv
module ptr_ext_decode
  import ptr_ext_pkg::*;
(
  input  logic [INSTR_W-1:0] word_i,
  input  logic               en_i,
  input  logic               second_i,
  output op_e                op_o,
  output logic [1:0]         sel_o,
  output logic [LIT6_W-1:0]  k6_o,
  output logic [LIT8_W-1:0]  k8_o,
  output logic [OFF_W-1:0]   off_o,
  output logic [ABS_W-1:0]   abs_o
);
  logic ff_ret;
  assign ff_ret = (word_i[7:6] == 2'b11);

  always_comb begin
    op_o = OP_NOP;
    if (second_i) begin
      op_o = OP_MV2;
    end else if (en_i) begin
      case (word_i[15:8])
        8'hE8:   op_o = ff_ret ? OP_ADD_RET : OP_ADD;
        8'hE9:   op_o = ff_ret ? OP_SUB_RET : OP_SUB;
        8'hEA:   op_o = OP_PUSH;
        8'hEB:   op_o = word_i[7] ? OP_MV_IDX1 : OP_MV_ABS1;
        8'h00:   op_o = (word_i[7:0] == 8'h14) ? OP_CALLW : OP_NOP;
        default: op_o = OP_NOP;
      endcase
    end
  end

  assign sel_o = ff_ret ? 2'd2 : word_i[7:6];
  assign k6_o  = word_i[LIT6_W-1:0];
  assign k8_o  = word_i[LIT8_W-1:0];
  assign off_o = word_i[OFF_W-1:0];
  assign abs_o = word_i[ABS_W-1:0];
endmodule

// File: rtl/ptr_ext_ptrfile.sv
module ptr_ext_ptrfile
  import ptr_ext_pkg::*;
#(
  parameter int unsigned PTR_W = 12
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   ld_i,
  input  logic [1:0]             ld_sel_i,
  input  logic [PTR_W-1:0]       ld_val_i,
  input  logic                   upd_i,
  input  logic [1:0]             upd_sel_i,
  input  logic [PTR_W-1:0]       upd_val_i,
  output logic [N_PTR*PTR_W-1:0] ptrs_o
);
  for (genvar g = 0; g < N_PTR; g++) begin : g_ptr
    logic [PTR_W-1:0] q;
    // core load wins over execution on the same pointer
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             q <= '0;
      else if (ld_i && ld_sel_i == 2'(g))      q <= ld_val_i;
      else if (upd_i && upd_sel_i == 2'(g))    q <= upd_val_i;
    end
    assign ptrs_o[g*PTR_W +: PTR_W] = q;
  end
endmodule

// File: rtl/ptr_ext_mover.sv
module ptr_ext_mover #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abs_i,
  input  logic              finish_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              wait_o,
  output logic              abs_o,
  output logic [DATA_W-1:0] wdata_o
);
  logic              wait_q, abs_q, fresh_q;
  logic [DATA_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q  <= 1'b0;
      abs_q   <= 1'b0;
      fresh_q <= 1'b0;
      hold_q  <= '0;
    end else begin
      fresh_q <= start_i;
      if (fresh_q) hold_q <= rdata_i;
      if (start_i) begin
        wait_q <= 1'b1;
        abs_q  <= abs_i;
      end else if (finish_i) begin
        wait_q <= 1'b0;
      end
    end
  end

  // read data arrives one cycle after the request; keep it for late second words
  assign wdata_o = fresh_q ? rdata_i : hold_q;
  assign wait_o  = wait_q;
  assign abs_o   = abs_q;
endmodule

// File: rtl/ptr_ext_unit.sv
module ptr_ext_unit
  import ptr_ext_pkg::*;
#(
  parameter int unsigned PTR_W  = 12,
  parameter int unsigned DATA_W = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   ext_en_i,
  input  logic                   instr_valid_i,
  input  logic [INSTR_W-1:0]     instr_i,
  input  logic                   ptr_ld_i,
  input  logic [1:0]             ptr_ld_sel_i,
  input  logic [PTR_W-1:0]       ptr_ld_val_i,
  input  logic [DATA_W-1:0]      mem_rdata_i,
  output logic                   mem_re_o,
  output logic                   mem_we_o,
  output logic [PTR_W-1:0]       mem_addr_o,
  output logic [DATA_W-1:0]      mem_wdata_o,
  output logic                   done_o,
  output logic [CYC_W-1:0]       cyc_o,
  output logic                   call_req_o,
  output logic                   ret_req_o,
  output logic [N_PTR*PTR_W-1:0] ptr_o
);
  op_e               dec_op, op;
  logic [1:0]        dec_sel;
  logic [LIT6_W-1:0] dec_k6;
  logic [LIT8_W-1:0] dec_k8;
  logic [OFF_W-1:0]  dec_off;
  logic [ABS_W-1:0]  dec_abs;

  logic              mv_wait, mv_abs;
  logic [DATA_W-1:0] mv_wdata;
  logic              mv_start, mv_finish;

  logic              upd;
  logic [1:0]        upd_sel;
  logic [PTR_W-1:0]  upd_val;

  logic [PTR_W-1:0]  ptr2, ptr_f, idx_addr;

  ptr_ext_decode u_dec (
    .word_i   (instr_i),
    .en_i     (ext_en_i),
    .second_i (mv_wait),
    .op_o     (dec_op),
    .sel_o    (dec_sel),
    .k6_o     (dec_k6),
    .k8_o     (dec_k8),
    .off_o    (dec_off),
    .abs_o    (dec_abs)
  );

  assign op       = instr_valid_i ? dec_op : OP_NOP;
  assign ptr2     = ptr_o[2*PTR_W +: PTR_W];
  assign ptr_f    = ptr_o[dec_sel*PTR_W +: PTR_W];
  assign idx_addr = ptr2 + PTR_W'(dec_off);

  always_comb begin
    mem_re_o    = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    done_o      = instr_valid_i;
    cyc_o       = instr_valid_i ? CYC_W'(1) : '0;
    call_req_o  = 1'b0;
    ret_req_o   = 1'b0;
    upd         = 1'b0;
    upd_sel     = dec_sel;
    upd_val     = '0;
    mv_start    = 1'b0;
    mv_finish   = 1'b0;
    case (op)
      OP_ADD: begin
        upd     = 1'b1;
        upd_val = ptr_f + PTR_W'(dec_k6);
      end
      OP_SUB: begin
        upd     = 1'b1;
        upd_val = ptr_f - PTR_W'(dec_k6);
      end
      OP_ADD_RET, OP_SUB_RET: begin
        upd       = 1'b1;
        upd_sel   = 2'd2;
        upd_val   = (op == OP_ADD_RET) ? ptr2 + PTR_W'(dec_k6) : ptr2 - PTR_W'(dec_k6);
        ret_req_o = 1'b1;
        cyc_o     = CYC_W'(2);
      end
      OP_PUSH: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = ptr2;
        mem_wdata_o = DATA_W'(dec_k8);
        upd         = 1'b1;
        upd_sel     = 2'd2;
        upd_val     = ptr2 - PTR_W'(1);
      end
      OP_CALLW: begin
        call_req_o = 1'b1;
        cyc_o      = CYC_W'(2);
      end
      OP_MV_ABS1, OP_MV_IDX1: begin
        mem_re_o   = 1'b1;
        mem_addr_o = idx_addr;
        mv_start   = 1'b1;
        done_o     = 1'b0;
        cyc_o      = '0;
      end
      OP_MV2: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = mv_abs ? PTR_W'(dec_abs) : idx_addr;
        mem_wdata_o = mv_wdata;
        mv_finish   = 1'b1;
        cyc_o       = CYC_W'(2);
      end
      default: ;
    endcase
  end

  ptr_ext_mover #(.DATA_W(DATA_W)) u_mover (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (mv_start),
    .abs_i    (op == OP_MV_ABS1),
    .finish_i (mv_finish),
    .rdata_i  (mem_rdata_i),
    .wait_o   (mv_wait),
    .abs_o    (mv_abs),
    .wdata_o  (mv_wdata)
  );

  ptr_ext_ptrfile #(.PTR_W(PTR_W)) u_ptrs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_i      (ptr_ld_i),
    .ld_sel_i  (ptr_ld_sel_i),
    .ld_val_i  (ptr_ld_val_i),
    .upd_i     (upd),
    .upd_sel_i (upd_sel),
    .upd_val_i (upd_val),
    .ptrs_o    (ptr_o)
  );
endmodule

// File: rtl/ptr_ext_unit_chk.sv
module ptr_ext_unit_chk #(
  parameter int unsigned PTR_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ext_en_i,
  input logic             instr_valid_i,
  input logic             ptr_ld_i,
  input logic             mv_wait,
  input logic             mem_re_o,
  input logic             mem_we_o,
  input logic             done_o,
  input logic [1:0]       cyc_o,
  input logic             call_req_o,
  input logic             ret_req_o,
  input logic [3*PTR_W-1:0] ptr_o
);
  logic [PTR_W-1:0] ptr2;
  assign ptr2 = ptr_o[2*PTR_W +: PTR_W];

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_valid_i |-> !(done_o || mem_re_o || mem_we_o || call_req_o || ret_req_o));

  a_r3_ret_cost: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_req_o |-> (done_o && cyc_o == 2'd2));

  a_r4_push_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !mv_wait && !ptr_ld_i) |=> ptr2 == PTR_W'($past(ptr2) - 1'b1));

  a_r5_call_cost: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_req_o |-> (done_o && cyc_o == 2'd2 && !mem_we_o && !mem_re_o));

  a_r6_read_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> mv_wait);

  a_r6_read_not_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |-> (!done_o && !mem_we_o));

  a_r8_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_en_i && !mv_wait) |-> !(mem_re_o || mem_we_o || call_req_o || ret_req_o));

  a_r8_disabled_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_en_i && !mv_wait && !ptr_ld_i) |=> $stable(ptr_o));
endmodule

bind ptr_ext_unit ptr_ext_unit_chk #(.PTR_W(PTR_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ext_en_i      (ext_en_i),
  .instr_valid_i (instr_valid_i),
  .ptr_ld_i      (ptr_ld_i),
  .mv_wait       (mv_wait),
  .mem_re_o      (mem_re_o),
  .mem_we_o      (mem_we_o),
  .done_o        (done_o),
  .cyc_o         (cyc_o),
  .call_req_o    (call_req_o),
  .ret_req_o     (ret_req_o),
  .ptr_o         (ptr_o)
);

// File: tb/ptr_ext_unit_bench.sv
`timescale 1ns/1ps
module ptr_ext_unit_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ext_en = 1'b1;
  logic        valid = 1'b0;
  logic [15:0] instr = '0;
  logic        ld = 1'b0;
  logic [1:0]  ld_sel = '0;
  logic [11:0] ld_val = '0;
  logic [7:0]  rdata = '0;
  logic        mem_re, mem_we, done, call_req, ret_req;
  logic [11:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [1:0]  cyc;
  logic [35:0] ptrs;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  bit          finished = 1'b0;

  logic [11:0] m_ptr [3];
  bit          m_wait = 1'b0;
  bit          m_abs = 1'b0;
  logic [7:0]  m_rd = '0;
  string       last_req = "R1";

  always #2.5 clk = ~clk;

  ptr_ext_unit u_ptr_ext_unit (
    .clk_i (clk), .rst_ni (rst_ni), .ext_en_i (ext_en),
    .instr_valid_i (valid), .instr_i (instr),
    .ptr_ld_i (ld), .ptr_ld_sel_i (ld_sel), .ptr_ld_val_i (ld_val),
    .mem_rdata_i (rdata),
    .mem_re_o (mem_re), .mem_we_o (mem_we), .mem_addr_o (mem_addr),
    .mem_wdata_o (mem_wdata), .done_o (done), .cyc_o (cyc),
    .call_req_o (call_req), .ret_req_o (ret_req), .ptr_o (ptrs)
  );

  function automatic logic [7:0] mem_fn(input logic [11:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h3C;
  endfunction

  always @(posedge clk) if (mem_re) rdata <= mem_fn(mem_addr);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // bundle: re we addr wdata done cyc call ret
  function automatic logic [27:0] pack(input bit re, we, input logic [11:0] a,
                                       input logic [7:0] d, input bit dn,
                                       input logic [1:0] c, input bit cl, rt);
    return {re, we, a, d, dn, c, cl, rt};
  endfunction

  task automatic step(input bit v, input logic [15:0] w, input bit e);
    logic [27:0] exp;
    string       req;
    logic [7:0]  hi;
    logic [1:0]  ff;
    logic [11:0] p2;
    @(negedge clk);
    valid = v; instr = w; ext_en = e;
    #1;
    check({last_req, " ptr"}, 64'(ptrs), 64'({m_ptr[2], m_ptr[1], m_ptr[0]}));
    hi = w[15:8]; ff = w[7:6]; p2 = m_ptr[2];
    exp = '0; req = "R9";
    if (!v) begin
      req = m_wait ? "R11" : "R1";
    end else if (m_wait) begin
      req = m_abs ? "R6" : "R7";
      exp = pack(0, 1, m_abs ? w[11:0] : p2 + 12'(w[6:0]), m_rd, 1, 2, 0, 0);
      m_wait = 1'b0;
    end else if (!e && (hi inside {8'hE8, 8'hE9, 8'hEA, 8'hEB} || w == 16'h0014)) begin
      req = "R8";
      exp = pack(0, 0, 0, 0, 1, 1, 0, 0);
    end else if (hi == 8'hE8 || hi == 8'hE9) begin
      if (ff == 2'b11) begin
        req = "R3";
        exp = pack(0, 0, 0, 0, 1, 2, 0, 1);
        m_ptr[2] = (hi == 8'hE8) ? p2 + 12'(w[5:0]) : p2 - 12'(w[5:0]);
      end else begin
        req = "R2";
        exp = pack(0, 0, 0, 0, 1, 1, 0, 0);
        m_ptr[ff] = (hi == 8'hE8) ? m_ptr[ff] + 12'(w[5:0]) : m_ptr[ff] - 12'(w[5:0]);
      end
    end else if (hi == 8'hEA) begin
      req = "R4";
      exp = pack(0, 1, p2, w[7:0], 1, 1, 0, 0);
      m_ptr[2] = p2 - 12'd1;
    end else if (hi == 8'hEB) begin
      req = w[7] ? "R7" : "R6";
      exp = pack(1, 0, p2 + 12'(w[6:0]), 0, 0, 0, 0, 0);
      m_rd = mem_fn(p2 + 12'(w[6:0]));
      m_wait = 1'b1; m_abs = !w[7];
    end else if (w == 16'h0014) begin
      req = "R5";
      exp = pack(0, 0, 0, 0, 1, 2, 1, 0);
    end else begin
      exp = pack(0, 0, 0, 0, 1, 1, 0, 0);
    end
    check(req, 64'(pack(mem_re, mem_we, mem_addr, mem_wdata, done, cyc, call_req, ret_req)), 64'(exp));
    last_req = req;
  endtask

  task automatic load(input logic [1:0] s, input logic [11:0] val);
    @(negedge clk);
    valid = 1'b0; ld = 1'b1; ld_sel = s; ld_val = val;
    @(negedge clk);
    ld = 1'b0;
    m_ptr[s] = val;
    last_req = "R12";
  endtask

  function automatic logic [15:0] rand_word(input bit second);
    int unsigned c;
    c = $urandom % 10;
    if (second) return (c < 8) ? {4'hF, 12'($urandom)} : 16'($urandom);
    case (c)
      0, 1: return {8'hE8, 8'($urandom)};
      2, 3: return {8'hE9, 8'($urandom)};
      4:    return {8'hEA, 8'($urandom)};
      5, 6: return {8'hEB, 8'($urandom)};
      7:    return 16'h0014;
      8:    return {4'hF, 12'($urandom)};
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 3; i++) m_ptr[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    step(0, 16'h0000, 1);                       // R1 reset state
    load(0, 12'h100); load(1, 12'h0FF0 >> 4); load(2, 12'h000);  // R12
    step(1, 16'hE83F, 1);                       // R2 add 63 to ptr0
    step(1, 16'hE945, 1);                       // R2 sub 5 from ptr1
    step(1, 16'hEA77, 1);                       // R4/R10 push at ptr2=0 wraps
    step(1, 16'hE8C3, 1);                       // R3 add+return on ptr2
    step(1, 16'hE9C1, 1);                       // R3 sub+return
    load(0, 12'hFFA);
    step(1, 16'hE83F, 1);                       // R10 wrap on add
    step(1, 16'h0014, 1);                       // R5
    load(2, 12'hFF0);
    step(1, 16'hEB7F, 1);                       // R6 read ptr2+127 wraps
    step(1, 16'hF123, 1);                       // R6 write abs
    step(1, 16'hEB85, 1);                       // R7 read
    step(0, 16'h0000, 1);                       // R11 gap
    step(0, 16'h0000, 1);
    step(0, 16'h0000, 1);
    step(1, 16'hF07A, 1);                       // R7/R11 write idx
    step(1, 16'hE811, 0);                       // R8
    step(1, 16'hE9C2, 0);
    step(1, 16'hEA55, 0);
    step(1, 16'hEB01, 0);
    step(1, 16'h0014, 0);
    step(1, 16'hF456, 1);                       // R9 lone second-word prefix
    step(1, 16'h1234, 1);                       // R9 standard word
    for (int i = 0; i < 1500; i++) begin
      if ($urandom % 5 == 0) step(0, 16'h0000, 1'($urandom % 2));
      else step(1, rand_word(m_wait), ($urandom % 6) != 0);
      if ($urandom % 40 == 0 && !m_wait) load(2'($urandom % 3), 12'($urandom));
    end
    step(0, 16'h0000, 1);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule